// File: doc/BRIEF.md
# Receive DMA Request Limiter

This block sits between the receive FIFO of a serial protocol engine and an external DMA controller. When a new packet starts to arrive, it raises a DMA request whenever the FIFO holds data, so that the DMA controller moves received bytes out one acknowledge at a time. Each acknowledge moves one byte and adds one to a byte counter.

Each DMA buffer is limited to a programmable number of bytes. Requesting stops when the buffer is full or when the last byte of a packet has been moved, whichever happens first. Each stop has its own sticky interrupt flag. Requesting then stays off until the CPU writes a restart command, which clears the byte counter and may load a new size limit in the same write. If the limit is turned off, or set larger than any packet, each buffer holds exactly one packet and the buffer-full flag never rises.

A small byte-wide register port sets the limit, the limit-off bit and the restart command. It also reads back the byte counter and the interrupt status.

Top module: `rx_dma_limiter`

## Requirements
- R1: After reset `dma_req` is low, both interrupt outputs are low, the byte count (addresses 2 and 3) reads 0, and the size limit reads back the `RESET_SIZE` parameter (address 0 returns bits 7:0).
- R2: Out of reset the block is armed. It raises no request until `pkt_start` is sampled high. From then on `dma_req` is high exactly while the block is active and `fifo_empty` is low.
- R3: Each clock edge with `dma_req` and `dma_ack` both high adds one to the byte count. An acknowledge while `dma_req` is low leaves the count unchanged.
- R4: With the limit on, an acknowledged byte that is not the packet's last and brings the count to the size limit stops requesting and sets the buffer-full flag (status bit 0, output `irq_buf_full`).
- R5: An acknowledged byte with `head_eop` high stops requesting and sets the transfer-end flag (status bit 1, output `irq_xfer_end`). If it also reaches the limit, only the transfer-end flag is set.
- R6: With the limit-off bit set (bit 6 of a write to address 1), the count never causes a stop, and a packet of any length ends with a transfer-end only.
- R7: After either stop, `dma_req` stays low, whatever the FIFO and `pkt_start` do, until a restart command is written. A write to address 1 with bit 7 clear does not restart.
- R8: A write to address 1 with bit 7 set restarts. In that same write it loads the limit's upper bits (bits 5:0) and the limit-off bit (bit 6), and it clears the count to 0. After a buffer-full stop the block resumes requesting in the same packet. After a transfer-end stop it re-arms and waits for `pkt_start`.
- R9: The 16-bit byte count reads as its low byte at address 2 and its high byte at address 3. The limit's low byte is written at address 0.
- R10: Status at address 4 gives buffer-full in bit 0, transfer-end in bit 1 and active in bit 2. Both flags stay set until a status read clears them. A new event in the same cycle as the read wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | Pulse: a new packet has begun entering the FIFO |
| fifo_empty | input | 1 | Receive FIFO holds no byte |
| head_eop | input | 1 | Byte at the FIFO head is the last of its packet |
| dma_req | output | 1 | Request to the DMA controller |
| dma_ack | input | 1 | DMA controller moves one byte this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears flags) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle of the read |
| irq_buf_full | output | 1 | Sticky buffer-full flag |
| irq_xfer_end | output | 1 | Sticky transfer-end flag |

## Verification
The bench builds the block with the default widths (14-bit limit, 16-bit counter) and `RESET_SIZE` set to 4. With that setting a buffer-full stop happens within a few bytes right after reset. The limit-off case runs a 300-byte packet, which drives the count past 255 so that its high byte at address 3 is read as nonzero. One packet is sized to end on the very byte that reaches the limit, so the case where both stop conditions meet is covered.

// File: rtl/rxdl_pkg.sv
package rxdl_pkg;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HALT   = 2'd2
    } rxdl_st_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_SIZE_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_SIZE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd4;

    localparam int B_RESTART = 7;
    localparam int B_LIM_OFF = 6;

endpackage

// File: rtl/rxdl_ctrl.sv
module rxdl_ctrl
    import rxdl_pkg::*;
#(
    parameter int SIZE_W = 14,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start,
    input  logic              fifo_empty,
    input  logic              head_eop,
    input  logic              dma_ack,
    input  logic              restart,
    input  logic [SIZE_W-1:0] max_size,
    input  logic              lim_dis,
    output logic              dma_req,
    output logic              evt_full,
    output logic              evt_end,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              active
);

    typedef struct packed {
        rxdl_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic             mid;
    } ctrl_s;

    ctrl_s r_q, r_d;

    logic             take;
    logic [CNT_W-1:0] cnt_inc;
    logic             at_cap;

    always_comb begin
        dma_req  = (r_q.st == ST_ACTIVE) && !fifo_empty;
        take     = dma_req && dma_ack;
        cnt_inc  = r_q.cnt + CNT_W'(1);
        at_cap   = !lim_dis && (cnt_inc >= CNT_W'(max_size));
        evt_end  = take && !restart && head_eop;
        evt_full = take && !restart && !head_eop && at_cap;

        r_d = r_q;
        if (restart) begin
            r_d.cnt = '0;
            r_d.mid = 1'b0;
            if (r_q.st == ST_HALT) begin
                r_d.st = r_q.mid ? ST_ACTIVE : ST_ARMED;
            end
        end else begin
            case (r_q.st)
                ST_ARMED: begin
                    if (pkt_start) r_d.st = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (take) begin
                        r_d.cnt = cnt_inc;
                        if (evt_end) begin
                            r_d.st  = ST_HALT;
                            r_d.mid = 1'b0;
                        end else if (evt_full) begin
                            r_d.st  = ST_HALT;
                            r_d.mid = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_ARMED, cnt: '0, mid: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_q  = r_q.cnt;
    assign active = (r_q.st == ST_ACTIVE);

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_full || evt_end) |=> !dma_req); // R7
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !restart && !pkt_start) |=> !dma_req); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && !restart) |=> (cnt_q == CNT_W'($past(cnt_q) + 1))); // R3
    AST_CNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!(dma_req && dma_ack) && !restart) |=> $stable(cnt_q)); // R3
    AST_RESTART_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0)); // R8
    AST_ONE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_full, evt_end})); // R5

endmodule

// File: rtl/rxdl_regs.sv
module rxdl_regs
    import rxdl_pkg::*;
#(
    parameter int SIZE_W     = 14,
    parameter int CNT_W      = 16,
    parameter int RESET_SIZE = 1536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              evt_full,
    input  logic              evt_end,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              active,
    output logic [SIZE_W-1:0] max_size,
    output logic              lim_dis,
    output logic              restart,
    output logic [7:0]        reg_rdata,
    output logic              flag_full,
    output logic              flag_end
);

    localparam int HI_W = SIZE_W - 8;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              dis;
        logic              full;
        logic              fend;
    } regs_s;

    regs_s r_q, r_d;

    logic        wr_lo, wr_hi, clr;
    logic [15:0] cnt16;
    logic [5:0]  hi6;

    always_comb begin
        wr_lo   = reg_wr && (reg_addr == A_SIZE_LO);
        wr_hi   = reg_wr && (reg_addr == A_SIZE_HI);
        restart = wr_hi && reg_wdata[B_RESTART];
        clr     = reg_rd && (reg_addr == A_STATUS);
        cnt16   = 16'(cnt_q);
        hi6     = 6'(r_q.size[SIZE_W-1:8]);

        r_d = r_q;
        if (wr_lo) r_d.size[7:0] = reg_wdata;
        if (wr_hi) begin
            r_d.size[SIZE_W-1:8] = reg_wdata[HI_W-1:0];
            r_d.dis              = reg_wdata[B_LIM_OFF];
        end
        r_d.full = evt_full | (r_q.full & ~clr);
        r_d.fend = evt_end  | (r_q.fend & ~clr);

        case (reg_addr)
            A_SIZE_LO: reg_rdata = r_q.size[7:0];
            A_SIZE_HI: reg_rdata = {1'b0, r_q.dis, hi6};
            A_CNT_LO:  reg_rdata = cnt16[7:0];
            A_CNT_HI:  reg_rdata = cnt16[15:8];
            A_STATUS:  reg_rdata = {5'b0, active, r_q.fend, r_q.full};
            default:   reg_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{size: SIZE_W'(RESET_SIZE), dis: 1'b0, full: 1'b0, fend: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign max_size  = r_q.size;
    assign lim_dis   = r_q.dis;
    assign flag_full = r_q.full;
    assign flag_end  = r_q.fend;

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_full && !clr) |=> flag_full); // R10
    AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_end && !clr) |=> flag_end); // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt_full && !evt_end) |=> (!flag_full && !flag_end)); // R10

endmodule

// File: rtl/rx_dma_limiter.sv
module rx_dma_limiter
    import rxdl_pkg::*;
#(
    parameter int SIZE_W     = 14,
    parameter int CNT_W      = 16,
    parameter int RESET_SIZE = 1536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pkt_start,
    input  logic       fifo_empty,
    input  logic       head_eop,
    output logic       dma_req,
    input  logic       dma_ack,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_buf_full,
    output logic       irq_xfer_end
);

    logic [SIZE_W-1:0] max_size;
    logic              lim_dis;
    logic              restart;
    logic              evt_full;
    logic              evt_end;
    logic [CNT_W-1:0]  cnt_q;
    logic              active;

    rxdl_regs #(
        .SIZE_W     (SIZE_W),
        .CNT_W      (CNT_W),
        .RESET_SIZE (RESET_SIZE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .evt_full  (evt_full),
        .evt_end   (evt_end),
        .cnt_q     (cnt_q),
        .active    (active),
        .max_size  (max_size),
        .lim_dis   (lim_dis),
        .restart   (restart),
        .reg_rdata (reg_rdata),
        .flag_full (irq_buf_full),
        .flag_end  (irq_xfer_end)
    );

    rxdl_ctrl #(
        .SIZE_W (SIZE_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_start  (pkt_start),
        .fifo_empty (fifo_empty),
        .head_eop   (head_eop),
        .dma_ack    (dma_ack),
        .restart    (restart),
        .max_size   (max_size),
        .lim_dis    (lim_dis),
        .dma_req    (dma_req),
        .evt_full   (evt_full),
        .evt_end    (evt_end),
        .cnt_q      (cnt_q),
        .active     (active)
    );

    AST_NO_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !dma_req); // R2

endmodule

// File: tb/sim_rx_dma_limiter.sv
module sim_rx_dma_limiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_start = 1'b0;
    logic       fifo_empty = 1'b1;
    logic       head_eop = 1'b0;
    logic       dma_req;
    logic       dma_ack = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_buf_full;
    logic       irq_xfer_end;

    rx_dma_limiter #(.SIZE_W(14), .CNT_W(16), .RESET_SIZE(4)) u0 (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .fifo_empty(fifo_empty),
        .head_eop(head_eop), .dma_req(dma_req), .dma_ack(dma_ack),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_buf_full(irq_buf_full), .irq_xfer_end(irq_xfer_end)
    );

    always #10 clk = ~clk; // 50 MHz

    localparam int K_FULL = 1;
    localparam int K_END  = 2;

    typedef struct { int kind; int cnt; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int fails = 0;
    int rem = 0;
    bit start_pend = 0;
    bit ack_force = 0;
    bit req_seen = 0;
    bit done = 0;
    int acks = 0;
    bit pf = 0, pe = 0;
    int cyc = 0;

    task automatic chk(string r, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, expv);
        end
    endtask

    task automatic expect_evt(int kind, int cnt);
        exp_t e;
        e.kind = kind;
        e.cnt = cnt;
        exp_q.push_back(e);
    endtask

    task automatic step();
        bit fired;
        @(negedge clk);
        fifo_empty = (rem == 0);
        head_eop   = (rem == 1);
        pkt_start  = start_pend;
        start_pend = 0;
        #1;
        req_seen = req_seen | dma_req;
        dma_ack  = ack_force | dma_req;
        fired    = dma_ack & dma_req;
        @(posedge clk);
        if (fired) rem--;
        #1;
        dma_ack   = 1'b0;
        pkt_start = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic reg_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output int v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = int'(reg_rdata);
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    // scoreboard monitor
    task automatic take_evt(int kind);
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R4/R5 unexpected stop actual=%0d expected=none", kind);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.cnt != acks) begin
                fails++;
                $display("FAIL R4/R5 stop kind/bytes actual=%0d/%0d expected=%0d/%0d",
                         kind, acks, e.kind, e.cnt);
            end
        end
        acks = 0;
    endtask

    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            if (irq_buf_full && !pf) take_evt(K_FULL);
            if (irq_xfer_end && !pe) take_evt(K_END);
            pf = irq_buf_full;
            pe = irq_xfer_end;
            if (dma_req && dma_ack) acks++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 dma_req", int'(dma_req), 0);
        chk("R1 irq_buf_full", int'(irq_buf_full), 0);
        chk("R1 irq_xfer_end", int'(irq_xfer_end), 0);
        reg_read(3'd2, v); chk("R1 count lo", v, 0);
        reg_read(3'd0, v); chk("R1 size lo", v, 4);
        reg_read(3'd4, v); chk("R1 status", v, 0);

        // R2 armed: no request until pkt_start
        rem = 3; req_seen = 0;
        run(5);
        chk("R2 no req before start", int'(req_seen), 0);
        expect_evt(K_END, 3);
        start_pend = 1;
        run(8);
        chk("R2 req after start", int'(req_seen), 1);
        chk("R5 fifo drained", rem, 0);
        reg_read(3'd2, v); chk("R9 count lo", v, 3);
        reg_read(3'd4, v); chk("R10 status end", v, 2);
        reg_read(3'd4, v); chk("R10 cleared by read", v, 0);

        // R7 halted: no requests, plain write to addr 1 does not restart
        rem = 6; start_pend = 1; req_seen = 0;
        run(5);
        chk("R7 halted no req", int'(req_seen), 0);
        reg_write(3'd1, 8'h00);
        run(3);
        chk("R7 write without restart", int'(req_seen), 0);

        // R8 restart after transfer end re-arms; R4 buffer full at 4
        reg_write(3'd1, 8'h80);
        reg_read(3'd2, v); chk("R8 count cleared", v, 0);
        run(3);
        chk("R8 re-armed waits for start", int'(req_seen), 0);
        expect_evt(K_FULL, 4);
        start_pend = 1;
        run(10);
        chk("R4 bytes left in fifo", rem, 2);
        chk("R4 irq_buf_full", int'(irq_buf_full), 1);
        reg_read(3'd4, v); chk("R4 status full", v, 1);

        // R8 restart after buffer full resumes same packet, new size loaded
        reg_write(3'd0, 8'h05);
        expect_evt(K_END, 2);
        reg_write(3'd1, 8'h80);
        run(6);
        chk("R8 resumed to packet end", rem, 0);
        reg_read(3'd0, v); chk("R8 size lo loaded", v, 5);
        reg_read(3'd2, v); chk("R8 count after resume", v, 2);
        reg_read(3'd4, v); chk("R5 status end", v, 2);

        // R6 limit off: 300-byte packet, one transfer end
        reg_write(3'd0, 8'h02);
        reg_write(3'd1, 8'hC0);
        reg_read(3'd1, v); chk("R6 limit-off bit", v, 8'h40);
        rem = 300;
        expect_evt(K_END, 300);
        start_pend = 1;
        run(310);
        chk("R6 whole packet moved", rem, 0);
        chk("R6 no buf full", int'(irq_buf_full), 0);
        reg_read(3'd2, v); chk("R9 count lo 300", v, 44);
        reg_read(3'd3, v); chk("R9 count hi 300", v, 1);
        reg_read(3'd4, v);

        // R5 end and cap on the same byte
        reg_write(3'd0, 8'h03);
        reg_write(3'd1, 8'h80);
        rem = 3;
        expect_evt(K_END, 3);
        start_pend = 1;
        run(8);
        run(5);
        chk("R10 end flag sticky", int'(irq_xfer_end), 1);
        chk("R5 end wins over full", int'(irq_buf_full), 0);

        // R3 acknowledge without request ignored
        ack_force = 1; rem = 0;
        run(4);
        ack_force = 0;
        reg_read(3'd2, v); chk("R3 stray ack ignored", v, 3);
        reg_read(3'd4, v); chk("R10 status end only", v, 2);

        run(3);
        chk("R4/R5 all stops seen", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule